// File: doc/BRIEF.md
# Source Operand Decode Unit

This unit turns the 5-bit source field of a 16-bit instruction into a 16-bit source operand. An addressing mode and an instruction class arrive with the instruction word, and a single `start` pulse begins the decode. The mode says how the field is read. It can be a signed literal, or a value taken from the next instruction word. It can also be a memory word whose address comes from a register, from the stack pointer, or from the next instruction word.

The sequencer is a four-state machine. **IDLE** waits for `start` and checks that the mode, class and field fit together. From IDLE there are three transitions. *launch-done* goes straight to DONE, for a literal or an illegal request. *launch-fetch* goes to FETCH_EXT, for the immediate-long and absolute modes. *launch-read* goes to MEM_READ, for register-indirect and stack-pointer-indirect.

**FETCH_EXT** raises `ext_ready` until the following instruction word is handed over. Its transition *ext-value* goes to DONE for immediate-long, and *ext-address* goes to MEM_READ for absolute. **MEM_READ** holds a read request until the memory accepts it, then takes *read-done* to DONE. **DONE** raises `done` for one cycle and takes *retire* back to IDLE. The operand and the illegal flag stay unchanged until the next `start`.

Top module: `srcop_decoder`

## Requirements
- R1: In literal mode (`addr_mode`=0), field bits 4..0 are a two's-complement value from -16 (10000) to +15 (01111). The operand is that value sign-extended to 16 bits. Any instruction class is accepted.
- R2: Immediate-long mode (`addr_mode`=1) requires the field 11111. The unit holds `ext_ready` high until `ext_valid`, and the operand is the `ext_word` taken in that cycle.
- R3: In register-indirect mode (`addr_mode`=2), `rf_raddr` carries the register: bit 5 = 1 selects the index bank and bits 4..0 hold the register number. Codes 00000..01111 select data registers 0..15. The even codes 1xxx0 select index register 2·x, that is index 0..14. Codes 10001, 10011, 11001 and 11011 select data registers 16, 17, 18 and 19. Code 10101 selects index register 16 and code 11101 selects index register 18.
- R4: In register-indirect mode the value read on `rf_rdata` is driven on `mem_addr`, and the operand is the memory word at that address.
- R5: Memory data is MEM_W (32) bits wide. The operand keeps only bits 15..0, and the upper bits are dropped.
- R6: In register-indirect mode, codes 10111 and 11111 are reserved. They set `illegal` and no memory read is issued.
- R7: Mode and class restrictions apply, using the class codes load=0, store=1, input=2, output=3, push=4, pop=5, other=6. Register-indirect and absolute modes are legal only for classes 0..3. Stack-pointer-indirect is legal only for classes 4..5. Mode codes 5..7 are never legal. An illegal request sets `illegal`, forces the operand to zero, and neither fetches a word nor reads memory.
- R8: Stack-pointer-indirect mode (`addr_mode`=3) requires the field 10111. It reads memory at `sp_value`.
- R9: In absolute mode (`addr_mode`=4), the fetched next word is the memory address, and the operand is the data read there.
- R10: `done` is a single-cycle pulse. It is high in the cycle that follows the edge that completes the last step.
- R11: The operand and `illegal` hold their values after `done` until the next accepted `start`. A `start` that arrives while a decode is in progress is ignored.
- R12: `mem_rd_valid` and `mem_addr` hold steady until `mem_rd_ready` is seen. Each decode makes at most one request.
- R13: Reset, which may arrive at any point in a sequence, returns the unit to IDLE with operand 0, `illegal` low and no `done`, `ext_ready` or `mem_rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a decode (taken in IDLE only) |
| addr_mode | input | 3 | Addressing mode code |
| op_class | input | 3 | Instruction class code |
| instr_word | input | 16 | Instruction word; bits 4..0 are the source field |
| ext_valid | input | 1 | Following instruction word is present |
| ext_word | input | 16 | Following instruction word |
| ext_ready | output | 1 | Unit is waiting for the following word |
| rf_raddr | output | 6 | Register read address {bank, number} |
| rf_rdata | input | 16 | Register read data (same cycle) |
| sp_value | input | 16 | Stack pointer contents |
| mem_rd_valid | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rd_ready | input | 1 | Memory accepts request; data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| operand | output | 16 | Resolved source operand |
| illegal | output | 1 | Illegal encoding or combination |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each result has a fixed due cycle, counted from the clock edge that samples `start`. A literal or illegal request shows `done` one cycle later. Immediate-long and register or stack indirect requests take two cycles, and absolute takes three. Every cycle that the bench's responders delay `ext_valid` or `mem_rd_ready` adds one cycle to these counts. The bench drives and samples on falling edges and counts the cycles until `done` appears. It compares that count with the value due and then reads the operand and flag in that same cycle. It also checks that `done` has dropped one cycle later and that the memory and word-fetch counts match the mode.

// File: rtl/srcop_pkg.sv
package srcop_pkg;

    localparam int FIELD_W = 5;

    // addressing mode codes
    localparam logic [2:0] AM_LITERAL  = 3'd0;
    localparam logic [2:0] AM_IMM_LONG = 3'd1;
    localparam logic [2:0] AM_REG_IND  = 3'd2;
    localparam logic [2:0] AM_SP_IND   = 3'd3;
    localparam logic [2:0] AM_ABSOLUTE = 3'd4;

    // instruction class codes
    localparam logic [2:0] CL_LOAD   = 3'd0;
    localparam logic [2:0] CL_STORE  = 3'd1;
    localparam logic [2:0] CL_INPUT  = 3'd2;
    localparam logic [2:0] CL_OUTPUT = 3'd3;
    localparam logic [2:0] CL_PUSH   = 3'd4;
    localparam logic [2:0] CL_POP    = 3'd5;

    localparam logic [FIELD_W-1:0] CODE_ALL_ONES = 5'b11111;
    localparam logic [FIELD_W-1:0] CODE_STACK    = 5'b10111;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FETCH_EXT = 2'd1,
        ST_MEM_READ  = 2'd2,
        ST_DONE      = 2'd3
    } seq_state_e;

endpackage

// File: rtl/srcop_field_map.sv
module srcop_field_map
    import srcop_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int RADDR_W = 6
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [2:0]         mode,
    input  logic [2:0]         cls,
    output logic               legal,
    output logic               need_ext,
    output logic               need_mem,
    output logic               sel_sp,
    output logic [DATA_W-1:0]  lit_val,
    output logic [RADDR_W-1:0] rf_raddr
);
    localparam int REG_NUM_W = RADDR_W - 1;
    localparam int EXT_W     = DATA_W - FIELD_W;

    logic                 cls_io;
    logic                 cls_stack;
    logic                 code_rsvd;
    logic                 idx_bank;
    logic [REG_NUM_W-1:0] reg_num;

    // register map for indirect codes
    always_comb begin
        if (!field[4]) begin
            idx_bank = 1'b0;
            reg_num  = REG_NUM_W'(field);
        end else if (!field[0]) begin
            idx_bank = 1'b1;
            reg_num  = REG_NUM_W'(field[3:0]);
        end else begin
            idx_bank = field[2];
            reg_num  = REG_NUM_W'(5'd16 + {3'b000, field[3], field[1] & ~field[2]});
        end
    end

    assign rf_raddr = {idx_bank, reg_num};
    assign lit_val  = {{EXT_W{field[FIELD_W-1]}}, field};

    always_comb begin
        cls_io    = (cls == CL_LOAD) || (cls == CL_STORE) ||
                    (cls == CL_INPUT) || (cls == CL_OUTPUT);
        cls_stack = (cls == CL_PUSH) || (cls == CL_POP);
        code_rsvd = (field == CODE_ALL_ONES) || (field == CODE_STACK);
        legal     = 1'b0;
        need_ext  = 1'b0;
        need_mem  = 1'b0;
        sel_sp    = 1'b0;
        case (mode)
            AM_LITERAL: begin
                legal = 1'b1;
            end
            AM_IMM_LONG: begin
                legal    = (field == CODE_ALL_ONES);
                need_ext = 1'b1;
            end
            AM_REG_IND: begin
                legal    = cls_io && !code_rsvd;
                need_mem = 1'b1;
            end
            AM_SP_IND: begin
                legal    = cls_stack && (field == CODE_STACK);
                need_mem = 1'b1;
                sel_sp   = 1'b1;
            end
            AM_ABSOLUTE: begin
                legal    = cls_io;
                need_ext = 1'b1;
                need_mem = 1'b1;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/srcop_seq.sv
module srcop_seq
    import srcop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MEM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              legal,
    input  logic              need_ext,
    input  logic              need_mem,
    input  logic              sel_sp,
    input  logic [DATA_W-1:0] lit_val,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic [DATA_W-1:0] sp_value,
    input  logic              ext_valid,
    input  logic [DATA_W-1:0] ext_word,
    input  logic              mem_rd_ready,
    input  logic [MEM_W-1:0]  mem_rdata,
    output logic              ext_ready,
    output logic              mem_rd_valid,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] operand,
    output logic              illegal,
    output logic              done
);
    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] operand_q;
    logic              illegal_q;
    logic              ext_is_addr_q;
    logic              launch;
    logic              ext_take;
    logic              mem_take;
    logic              unused_hi;

    assign unused_hi = ^mem_rdata[MEM_W-1:DATA_W];

    assign launch   = start && (state_q == ST_IDLE);
    assign ext_take = ext_valid && (state_q == ST_FETCH_EXT);
    assign mem_take = mem_rd_ready && (state_q == ST_MEM_READ);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!legal)        state_d = ST_DONE;
                    else if (need_ext) state_d = ST_FETCH_EXT;
                    else if (need_mem) state_d = ST_MEM_READ;
                    else               state_d = ST_DONE;
                end
            end
            ST_FETCH_EXT: begin
                if (ext_valid) state_d = ext_is_addr_q ? ST_MEM_READ : ST_DONE;
            end
            ST_MEM_READ: begin
                if (mem_rd_ready) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        ext_ready    = (state_q == ST_FETCH_EXT);
        mem_rd_valid = (state_q == ST_MEM_READ);
        done         = (state_q == ST_DONE);
    end

    // operand and address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q        <= '0;
            operand_q     <= '0;
            illegal_q     <= 1'b0;
            ext_is_addr_q <= 1'b0;
        end else if (launch) begin
            illegal_q     <= !legal;
            ext_is_addr_q <= need_mem;
            addr_q        <= sel_sp ? sp_value : rf_rdata;
            if (!legal || need_ext || need_mem) operand_q <= '0;
            else                                operand_q <= lit_val;
        end else if (ext_take) begin
            if (ext_is_addr_q) addr_q    <= ext_word;
            else               operand_q <= ext_word;
        end else if (mem_take) begin
            operand_q <= mem_rdata[DATA_W-1:0];
        end
    end

    assign mem_addr = addr_q;
    assign operand  = operand_q;
    assign illegal  = illegal_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_addr))); // R12
    AST_EXT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ready && !ext_valid) |=> ext_ready); // R2
    AST_NO_MEM_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !illegal); // R6

endmodule

// File: rtl/srcop_decoder.sv
module srcop_decoder
    import srcop_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MEM_W   = 32,
    parameter int RADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         addr_mode,
    input  logic [2:0]         op_class,
    input  logic [DATA_W-1:0]  instr_word,
    input  logic               ext_valid,
    input  logic [DATA_W-1:0]  ext_word,
    output logic               ext_ready,
    output logic [RADDR_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0]  rf_rdata,
    input  logic [DATA_W-1:0]  sp_value,
    output logic               mem_rd_valid,
    output logic [DATA_W-1:0]  mem_addr,
    input  logic               mem_rd_ready,
    input  logic [MEM_W-1:0]   mem_rdata,
    output logic [DATA_W-1:0]  operand,
    output logic               illegal,
    output logic               done
);
    logic              legal;
    logic              need_ext;
    logic              need_mem;
    logic              sel_sp;
    logic [DATA_W-1:0] lit_val;
    logic              unused_instr;

    assign unused_instr = ^instr_word[DATA_W-1:FIELD_W];

    srcop_field_map #(
        .DATA_W  (DATA_W),
        .RADDR_W (RADDR_W)
    ) map_i (
        .field    (instr_word[FIELD_W-1:0]),
        .mode     (addr_mode),
        .cls      (op_class),
        .legal    (legal),
        .need_ext (need_ext),
        .need_mem (need_mem),
        .sel_sp   (sel_sp),
        .lit_val  (lit_val),
        .rf_raddr (rf_raddr)
    );

    srcop_seq #(
        .DATA_W (DATA_W),
        .MEM_W  (MEM_W)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .legal        (legal),
        .need_ext     (need_ext),
        .need_mem     (need_mem),
        .sel_sp       (sel_sp),
        .lit_val      (lit_val),
        .rf_rdata     (rf_rdata),
        .sp_value     (sp_value),
        .ext_valid    (ext_valid),
        .ext_word     (ext_word),
        .mem_rd_ready (mem_rd_ready),
        .mem_rdata    (mem_rdata),
        .ext_ready    (ext_ready),
        .mem_rd_valid (mem_rd_valid),
        .mem_addr     (mem_addr),
        .operand      (operand),
        .illegal      (illegal),
        .done         (done)
    );

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (operand == '0)); // R7
    AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(operand) && $stable(illegal))); // R11

endmodule

// File: tb/srcop_decoder_tb.sv
module srcop_decoder_tb_top;

    typedef struct packed {
        logic [2:0]  mode;
        logic [2:0]  cls;
        logic [4:0]  field;
        logic [15:0] xword;
        logic [15:0] exp_op;
        logic        exp_ill;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 3'd6, 5'b01111, 16'h0000, 16'h000F, 1'b0}, // R1 +15
        '{3'd0, 3'd6, 5'b10000, 16'h0000, 16'hFFF0, 1'b0}, // R1 -16
        '{3'd0, 3'd0, 5'b11111, 16'h0000, 16'hFFFF, 1'b0}, // R1 -1
        '{3'd0, 3'd6, 5'b00000, 16'h0000, 16'h0000, 1'b0}, // R1 zero
        '{3'd1, 3'd6, 5'b11111, 16'h1234, 16'h1234, 1'b0}, // R2
        '{3'd1, 3'd6, 5'b01010, 16'h1111, 16'h0000, 1'b1}, // R2 wrong field
        '{3'd2, 3'd0, 5'b00101, 16'h0000, 16'hFA5F, 1'b0}, // R3 data 5
        '{3'd2, 3'd1, 5'b10110, 16'h0000, 16'hFA7C, 1'b0}, // R3 index 6
        '{3'd2, 3'd2, 5'b11011, 16'h0000, 16'hFA49, 1'b0}, // R3 data 19
        '{3'd2, 3'd3, 5'b11101, 16'h0000, 16'hFA68, 1'b0}, // R3 index 18
        '{3'd2, 3'd0, 5'b10101, 16'h0000, 16'hFA6A, 1'b0}, // R3 index 16
        '{3'd2, 3'd0, 5'b10001, 16'h0000, 16'hFA4A, 1'b0}, // R3 data 16
        '{3'd2, 3'd0, 5'b10111, 16'h0000, 16'h0000, 1'b1}, // R6
        '{3'd2, 3'd0, 5'b11111, 16'h0000, 16'h0000, 1'b1}, // R6
        '{3'd2, 3'd6, 5'b00001, 16'h0000, 16'h0000, 1'b1}, // R7 class
        '{3'd3, 3'd4, 5'b10111, 16'h0000, 16'h25AA, 1'b0}, // R8 push
        '{3'd3, 3'd5, 5'b10111, 16'h0000, 16'h25AA, 1'b0}, // R8 pop
        '{3'd3, 3'd0, 5'b10111, 16'h0000, 16'h0000, 1'b1}, // R7 stack class
        '{3'd3, 3'd4, 5'b00111, 16'h0000, 16'h0000, 1'b1}, // R8 field
        '{3'd4, 3'd3, 5'b00000, 16'hC3C3, 16'h9999, 1'b0}, // R9
        '{3'd4, 3'd4, 5'b00000, 16'hC3C3, 16'h0000, 1'b1}, // R7 abs class
        '{3'd5, 3'd0, 5'b00000, 16'h0000, 16'h0000, 1'b1}, // R7 bad mode
        '{3'd2, 3'd0, 5'b11000, 16'h0000, 16'hFA72, 1'b0}, // R3 index 8
        '{3'd2, 3'd0, 5'b11100, 16'h0000, 16'hFA76, 1'b0}  // R3 index 12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  addr_mode = '0;
    logic [2:0]  op_class = '0;
    logic [15:0] instr_word = '0;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic        ext_ready;
    logic [5:0]  rf_raddr;
    logic [15:0] rf_rdata;
    logic [15:0] sp_value = 16'h7FF0;
    logic        mem_rd_valid;
    logic [15:0] mem_addr;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rdata;
    logic [15:0] operand;
    logic        illegal;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    int ext_left = 0;
    int mem_left = 0;
    int ext_xfers = 0;
    int mem_reqs = 0;
    logic [15:0] addr_seen = '0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign rf_rdata  = 16'hA000 | {10'd0, rf_raddr};
    assign mem_rdata = {~mem_addr, mem_addr ^ 16'h5A5A};

    srcop_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_mode(addr_mode),
        .op_class(op_class), .instr_word(instr_word), .ext_valid(ext_valid),
        .ext_word(ext_word), .ext_ready(ext_ready), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .sp_value(sp_value), .mem_rd_valid(mem_rd_valid),
        .mem_addr(mem_addr), .mem_rd_ready(mem_rd_ready), .mem_rdata(mem_rdata),
        .operand(operand), .illegal(illegal), .done(done)
    );

    // following-word and memory responders
    always @(negedge clk) begin
        if (ext_valid) ext_valid = 1'b0;
        else if (ext_ready) begin
            if (ext_left == 0) begin ext_valid = 1'b1; ext_xfers++; end
            else ext_left--;
        end
        if (mem_rd_ready) mem_rd_ready = 1'b0;
        else if (mem_rd_valid) begin
            if (mem_left == 0) begin
                mem_rd_ready = 1'b1; mem_reqs++; addr_seen = mem_addr;
            end else mem_left--;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] m, input logic [2:0] c, input logic [4:0] f,
                          input logic [15:0] xw, input int es, input int ms, output int cyc);
        @(negedge clk);
        addr_mode = m; op_class = c; instr_word = {11'h6C3, f}; ext_word = xw;
        ext_left = es; mem_left = ms; ext_xfers = 0; mem_reqs = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic check_after(input string req);
        @(negedge clk);
        check({req, " done single pulse"}, {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 operand", {16'd0, operand}, 32'd0);
        check("R13 illegal", {31'd0, illegal}, 32'd0);
        check("R13 done", {31'd0, done}, 32'd0);
        check("R13 idle outputs", {30'd0, ext_ready, mem_rd_valid}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            vec_t v = VEC[i];
            bit mem_exp = !v.exp_ill && (v.mode inside {3'd2, 3'd3, 3'd4});
            bit ext_exp = !v.exp_ill && (v.mode inside {3'd1, 3'd4});
            run_op(v.mode, v.cls, v.field, v.xword, 0, 0, cyc);
            // R10 latency: literal/illegal 1, plus one per fetch and per read
            check($sformatf("R10 vec%0d cycles", i), cyc, 1 + ext_exp + mem_exp);
            check($sformatf("R1/R4/R5 vec%0d operand", i), {16'd0, operand}, {16'd0, v.exp_op});
            check($sformatf("R7 vec%0d illegal", i), {31'd0, illegal}, {31'd0, v.exp_ill});
            check($sformatf("R6/R12 vec%0d reads", i), mem_reqs, mem_exp);
            check($sformatf("R2 vec%0d fetches", i), ext_xfers, ext_exp);
            if (mem_exp)
                check($sformatf("R4/R8/R9 vec%0d address", i), {16'd0, addr_seen},
                      {16'd0, v.exp_op ^ 16'h5A5A});
            check_after($sformatf("R10 vec%0d", i));
        end

        // R12 memory stall of 3 cycles
        run_op(3'd2, 3'd0, 5'b00011, 16'h0, 0, 3, cyc);
        check("R12 stalled read cycles", cyc, 5);
        check("R12 stalled read operand", {16'd0, operand}, 32'h0000FA59);
        check("R12 stalled read address", {16'd0, addr_seen}, 32'h0000A003);

        // R2 following word delayed by 2 cycles
        run_op(3'd1, 3'd6, 5'b11111, 16'hBEEF, 2, 0, cyc);
        check("R2 delayed word cycles", cyc, 4);
        check("R2 delayed word operand", {16'd0, operand}, 32'h0000BEEF);

        // R9 absolute with both stalls
        run_op(3'd4, 3'd1, 5'b01100, 16'h0F0F, 1, 2, cyc);
        check("R9 absolute cycles", cyc, 6);
        check("R9 absolute operand", {16'd0, operand}, 32'h00005555);
        check("R9 absolute address", {16'd0, addr_seen}, 32'h00000F0F);

        // R11 hold after done
        repeat (6) @(negedge clk);
        check("R11 operand held", {16'd0, operand}, 32'h00005555);
        check("R11 no extra done", {31'd0, done}, 32'd0);

        // R11 start while busy is ignored
        @(negedge clk);
        addr_mode = 3'd2; op_class = 3'd0; instr_word = 16'h0002;
        mem_left = 4; mem_reqs = 0; start = 1'b1;
        @(negedge clk);
        addr_mode = 3'd0; instr_word = 16'h0004;
        cyc = 1;
        @(negedge clk);
        start = 1'b0;
        cyc++;
        while (!done && cyc < 60) begin @(negedge clk); cyc++; end
        check("R11 busy start cycles", cyc, 6);
        check("R11 busy start operand", {16'd0, operand}, 32'h0000FA58);
        repeat (3) @(negedge clk);
        check("R11 no second decode", {16'd0, operand}, 32'h0000FA58);
        check("R11 single read", mem_reqs, 1);

        // R13 reset in the middle of a fetch
        @(negedge clk);
        addr_mode = 3'd1; op_class = 3'd6; instr_word = 16'h001F;
        ext_left = 20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R13 waiting before reset", {31'd0, ext_ready}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R13 reset ext_ready", {31'd0, ext_ready}, 32'd0);
        check("R13 reset operand", {16'd0, operand}, 32'd0);
        check("R13 reset flags", {30'd0, illegal, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R13 stays idle", {30'd0, ext_ready, mem_rd_valid}, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule